// File: doc/BRIEF.md
# Single-Bus Stack Datapath with Micro-Sequencer

This block is a compact processor datapath in which every register-to-register move shares one byte-wide internal bus. A control sequencer steps through micro-operations, one bus transfer per clock, for four operations: fetching an instruction byte, copying the fetched byte into operand register A, adding A to the last byte read from memory into R, and pushing R onto a downward-growing stack in memory.

The 16-bit address registers (program counter, stack pointer and memory address register) cross the byte bus one half at a time. Memory is reached only through the address register and the data buffer register, and each access takes two cycles. The stack pointer has its own decrementer, so lowering it costs no extra cycle. A caller pulses `start` with an operation code while the block is idle and waits for the one-cycle `done` pulse.

Top module: `stack_push_datapath`

## Requirements
- R1: After reset, `mem_rd`, `mem_wr` and `done` are low, `mem_addr` and `mem_wdata` are zero, the program counter is 0x0000 and the stack pointer is 0xFFFF.
- R2: With `op` = 2'b00 (fetch) sampled with `start` in the idle state at clock edge 0, `mem_rd` is high in cycles 3 and 4 after that edge, with `mem_addr` equal to the program counter. `done` is high in cycle 7 only, and `mem_wr` stays low.
- R3: Each fetch raises the program counter by one, so successive fetches read consecutive addresses.
- R4: With `op` = 2'b01 (push), `mem_wr` is high in cycles 4 and 5 after the start edge only, with `mem_addr` and `mem_wdata` held stable across both cycles. `done` is high in cycle 6.
- R5: A push writes to the stack pointer value from before the push, and the stack pointer then drops by one. Consecutive pushes therefore write to 0xFFFF, 0xFFFE, and so on.
- R6: The byte written by a push is the current content of R, which travels to memory through the data buffer register.
- R7: With `op` = 2'b10 (load A), the most recently fetched instruction byte is copied into A, and `done` is high in cycle 2.
- R8: With `op` = 2'b11 (add), B takes the data buffer byte, then R takes A + B modulo 256, and `done` is high in cycle 3.
- R9: A `start` that arrives while an operation is in progress is ignored, so the running sequence is unchanged.
- R10: `done` is a single-cycle pulse, and `mem_rd` and `mem_wr` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin the operation selected by `op`; sampled only while idle |
| op | input | 2 | Operation: 00 fetch, 01 push R, 10 load A, 11 add |
| mem_addr | output | 16 | Memory address, driven from the address register |
| mem_wdata | output | 8 | Memory write data, driven from the data buffer register |
| mem_rdata | input | 8 | Memory read data, valid one cycle after a read strobe |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| done | output | 1 | One-cycle pulse when an operation completes |

## Verification
A wrong stack pointer shows up as a wrong write address on the next push, four cycles after its start. A corrupted program counter shows up as a wrong read address three cycles into the next fetch. A fault in A, B or the adder is hidden until a later push writes R, so the bench chains fetch, load, add and push so that every internal value reaches `mem_wdata` within one sequence. Sequencer faults move the strobe and `done` cycles, and the scoreboard catches these because it compares each event against its expected cycle number.

// File: rtl/stkdp_pkg.sv
package stkdp_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 2 * DATA_W;

    typedef enum logic [1:0] {
        OP_FETCH = 2'b00,
        OP_PUSH  = 2'b01,
        OP_LDA   = 2'b10,
        OP_ADD   = 2'b11
    } op_e;

    typedef enum logic [3:0] {
        SRC_NONE, SRC_PC_LO, SRC_PC_HI, SRC_SP_LO, SRC_SP_HI,
        SRC_R, SRC_MDR, SRC_IR, SRC_ALU
    } bus_src_e;

    typedef enum logic [2:0] {
        DST_NONE, DST_MAR_LO, DST_MAR_HI, DST_MDR, DST_IR, DST_A, DST_B, DST_R
    } bus_dst_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_F_PCLO, S_F_PCHI, S_F_RD1, S_F_RD2, S_F_IR, S_F_INC,
        S_P_SPLO, S_P_SPHI, S_P_RMDR, S_P_WR1, S_P_WR2,
        S_LA_IR,
        S_AD_B, S_AD_R,
        S_DONE
    } state_e;

    typedef struct packed {
        bus_src_e src;
        bus_dst_e dst;
        logic     sp_dec;
        logic     pc_inc;
        logic     mem_rd;
        logic     mem_wr;
        logic     mdr_from_mem;
        logic     done;
    } uop_t;

    // Control word issued in each sequencer state: at most one bus transfer.
    function automatic uop_t state_uop(state_e s);
        uop_t u;
        u = '{src: SRC_NONE, dst: DST_NONE, default: 1'b0};
        case (s)
            S_F_PCLO: begin u.src = SRC_PC_LO; u.dst = DST_MAR_LO; end
            S_F_PCHI: begin u.src = SRC_PC_HI; u.dst = DST_MAR_HI; end
            S_F_RD1:  u.mem_rd = 1'b1;
            S_F_RD2:  begin u.mem_rd = 1'b1; u.mdr_from_mem = 1'b1; end
            S_F_IR:   begin u.src = SRC_MDR; u.dst = DST_IR; end
            S_F_INC:  u.pc_inc = 1'b1;
            S_P_SPLO: begin u.src = SRC_SP_LO; u.dst = DST_MAR_LO; end
            S_P_SPHI: begin u.src = SRC_SP_HI; u.dst = DST_MAR_HI; end
            S_P_RMDR: begin u.src = SRC_R; u.dst = DST_MDR; u.sp_dec = 1'b1; end
            S_P_WR1:  u.mem_wr = 1'b1;
            S_P_WR2:  u.mem_wr = 1'b1;
            S_LA_IR:  begin u.src = SRC_IR; u.dst = DST_A; end
            S_AD_B:   begin u.src = SRC_MDR; u.dst = DST_B; end
            S_AD_R:   begin u.src = SRC_ALU; u.dst = DST_R; end
            S_DONE:   u.done = 1'b1;
            default:  ;
        endcase
        return u;
    endfunction

    function automatic state_e first_state(op_e o);
        case (o)
            OP_FETCH: return S_F_PCLO;
            OP_PUSH:  return S_P_SPLO;
            OP_LDA:   return S_LA_IR;
            default:  return S_AD_B;
        endcase
    endfunction

endpackage

// File: rtl/stkdp_alu.sv
module stkdp_alu #(
    parameter int DW = stkdp_pkg::DATA_W
) (
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    output logic [DW-1:0] sum
);
    // Carry out is discarded: the result wraps modulo 2**DW.
    assign sum = opa + opb;
endmodule

// File: rtl/stkdp_ctrl.sv
module stkdp_ctrl
    import stkdp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [1:0] op,
    output uop_t       uop
);
    state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        case (state_q)
            S_IDLE:   if (start) state_d = first_state(op_e'(op));
            S_F_PCLO: state_d = S_F_PCHI;
            S_F_PCHI: state_d = S_F_RD1;
            S_F_RD1:  state_d = S_F_RD2;
            S_F_RD2:  state_d = S_F_IR;
            S_F_IR:   state_d = S_F_INC;
            S_F_INC:  state_d = S_DONE;
            S_P_SPLO: state_d = S_P_SPHI;
            S_P_SPHI: state_d = S_P_RMDR;
            S_P_RMDR: state_d = S_P_WR1;
            S_P_WR1:  state_d = S_P_WR2;
            S_P_WR2:  state_d = S_DONE;
            S_LA_IR:  state_d = S_DONE;
            S_AD_B:   state_d = S_AD_R;
            S_AD_R:   state_d = S_DONE;
            default:  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= S_IDLE;
        else     state_q <= state_d;
    end

    assign uop = state_uop(state_q);
endmodule

// File: rtl/stkdp_regs.sv
module stkdp_regs
    import stkdp_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  uop_t          uop,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mar_o,
    output logic [DW-1:0] mdr_o,
    output logic [AW-1:0] sp_o
);
    localparam logic [AW-1:0] SP_INIT = '1;

    logic [AW-1:0] pc_q, sp_q, mar_q;
    logic [DW-1:0] mdr_q, ir_q, a_q, b_q, r_q;
    logic [DW-1:0] bus;
    logic [DW-1:0] alu_y;

    stkdp_alu #(.DW(DW)) u_alu (
        .opa (a_q),
        .opb (b_q),
        .sum (alu_y)
    );

    // Single shared bus: exactly one source per cycle.
    always_comb begin
        case (uop.src)
            SRC_PC_LO: bus = pc_q[DW-1:0];
            SRC_PC_HI: bus = pc_q[AW-1:DW];
            SRC_SP_LO: bus = sp_q[DW-1:0];
            SRC_SP_HI: bus = sp_q[AW-1:DW];
            SRC_R:     bus = r_q;
            SRC_MDR:   bus = mdr_q;
            SRC_IR:    bus = ir_q;
            SRC_ALU:   bus = alu_y;
            default:   bus = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            sp_q  <= SP_INIT;
            mar_q <= '0;
            mdr_q <= '0;
            ir_q  <= '0;
            a_q   <= '0;
            b_q   <= '0;
            r_q   <= '0;
        end else begin
            if (uop.pc_inc) pc_q <= pc_q + 1'b1;
            if (uop.sp_dec) sp_q <= sp_q - 1'b1;
            if (uop.mdr_from_mem)         mdr_q <= mem_rdata;
            else if (uop.dst == DST_MDR)  mdr_q <= bus;
            case (uop.dst)
                DST_MAR_LO: mar_q[DW-1:0]  <= bus;
                DST_MAR_HI: mar_q[AW-1:DW] <= bus;
                DST_IR:     ir_q <= bus;
                DST_A:      a_q  <= bus;
                DST_B:      b_q  <= bus;
                DST_R:      r_q  <= bus;
                default:    ;
            endcase
        end
    end

    assign mar_o = mar_q;
    assign mdr_o = mdr_q;
    assign sp_o  = sp_q;
endmodule

// File: rtl/stack_push_datapath.sv
module stack_push_datapath
    import stkdp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        op,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              done
);
    uop_t              uop;
    logic [ADDR_W-1:0] sp_val;

    stkdp_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .op    (op),
        .uop   (uop)
    );

    stkdp_regs #(.DW(DATA_W), .AW(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .uop       (uop),
        .mem_rdata (mem_rdata),
        .mar_o     (mem_addr),
        .mdr_o     (mem_wdata),
        .sp_o      (sp_val)
    );

    assign mem_rd = uop.mem_rd;
    assign mem_wr = uop.mem_wr;
    assign done   = uop.done;
endmodule

// File: rtl/stkdp_checker.sv
module stkdp_checker
    import stkdp_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              done,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic [ADDR_W-1:0] sp_now
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!mem_rd && !mem_wr && !done && sp_now == '1));

    assert_read_pair_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_rd) |=> (mem_rd && $stable(mem_addr)));

    assert_write_pair_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_wr) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata)));

    assert_write_len_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && $past(mem_wr)) |=> !mem_wr);

    assert_done_after_write_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_wr) |-> done);

    assert_sp_below_written_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_wr) |-> (sp_now == ADDR_W'($past(mem_addr) - 1'b1)));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));
endmodule

bind stack_push_datapath stkdp_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .done      (done),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .sp_now    (sp_val)
);

// File: tb/tb_stack_push_datapath.sv
module tb_stack_push_datapath;

    typedef struct packed {
        logic [1:0]  kind;   // 0 read, 1 write, 2 done
        logic [15:0] addr;
        logic [7:0]  data;
        logic [31:0] cyc;
        logic [7:0]  req;
    } ev_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;
    logic        mem_rd, mem_wr, done;

    int unsigned cyc = 0;
    int          n_checks = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;
    ev_t         exp_q[$];

    // Reference model state, from the requirements.
    logic [15:0] m_pc = 16'h0000, m_sp = 16'hFFFF;
    logic [7:0]  m_ir = 8'h00, m_mdr = 8'h00, m_a = 8'h00, m_b = 8'h00, m_r = 8'h00;

    always #10 clk = ~clk;  // 50 MHz

    stack_push_datapath dut (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .op        (op),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .done      (done)
    );

    function automatic logic [7:0] mem_byte(logic [15:0] a);
        return 8'(a[7:0] * 8'd37 + 8'd200);
    endfunction

    // Behavioural synchronous memory: read data one cycle after the strobe.
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem_byte(mem_addr);
    end

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    task automatic expect_ev(logic [1:0] k, logic [15:0] a, logic [7:0] d,
                             int unsigned c, logic [7:0] rq);
        ev_t e;
        e.kind = k; e.addr = a; e.data = d; e.cyc = c; e.req = rq;
        exp_q.push_back(e);
    endtask

    // Monitor: every strobe or done pulse is popped and compared.
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (mem_rd && mem_wr) begin
                n_checks++; n_fail++;
                $display("FAIL R10: rd=%b wr=%b expected exclusive strobes", mem_rd, mem_wr);
            end
            if (mem_rd || mem_wr || done) begin
                ev_t act, ex;
                logic ok;
                act.kind = mem_wr ? 2'd1 : (mem_rd ? 2'd0 : 2'd2);
                act.addr = mem_addr; act.data = mem_wdata; act.cyc = cyc; act.req = 8'd0;
                n_checks++;
                if (exp_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL R10: unexpected event kind=%0d addr=%h data=%h cyc=%0d, expected none",
                             act.kind, act.addr, act.data, act.cyc);
                end else begin
                    ex = exp_q.pop_front();
                    ok = (act.kind == ex.kind) && (act.cyc == ex.cyc);
                    if (ex.kind != 2'd2) ok = ok && (act.addr == ex.addr);
                    if (ex.kind == 2'd1) ok = ok && (act.data == ex.data);
                    if (!ok) begin
                        n_fail++;
                        $display("FAIL R%0d: got kind=%0d addr=%h data=%h cyc=%0d, expected kind=%0d addr=%h data=%h cyc=%0d",
                                 ex.req, act.kind, act.addr, act.data, act.cyc,
                                 ex.kind, ex.addr, ex.data, ex.cyc);
                    end
                end
            end
        end
    end

    task automatic check_val(string tag, logic [15:0] got, logic [15:0] want);
        n_checks++;
        if (got !== want) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, want);
        end
    endtask

    // Driver: launches one operation and queues the events it must produce.
    task automatic run_op(logic [1:0] o, bit noise);
        int unsigned s;
        logic [7:0] rq_over;
        wait (exp_q.size() == 0);
        @(negedge clk);
        start = 1'b1; op = o;
        @(posedge clk); #1;
        s = cyc;
        rq_over = noise ? 8'd9 : 8'd0;  // R9: stray start while busy
        case (o)
            2'b00: begin  // fetch: R2, R3
                expect_ev(2'd0, m_pc, 8'h00, s + 2, noise ? rq_over : 8'd2);
                expect_ev(2'd0, m_pc, 8'h00, s + 3, noise ? rq_over : 8'd3);
                expect_ev(2'd2, 16'h0, 8'h00, s + 6, noise ? rq_over : 8'd2);
                m_ir = mem_byte(m_pc); m_mdr = m_ir; m_pc = m_pc + 16'd1;
            end
            2'b01: begin  // push: R4, R5, R6
                expect_ev(2'd1, m_sp, m_r, s + 3, noise ? rq_over : 8'd5);
                expect_ev(2'd1, m_sp, m_r, s + 4, noise ? rq_over : 8'd6);
                expect_ev(2'd2, 16'h0, 8'h00, s + 5, noise ? rq_over : 8'd4);
                m_mdr = m_r; m_sp = m_sp - 16'd1;
            end
            2'b10: begin  // load A: R7
                expect_ev(2'd2, 16'h0, 8'h00, s + 1, 8'd7);
                m_a = m_ir;
            end
            default: begin  // add: R8
                expect_ev(2'd2, 16'h0, 8'h00, s + 2, 8'd8);
                m_b = m_mdr; m_r = 8'(m_a + m_b);
            end
        endcase
        @(negedge clk);
        if (noise) begin
            start = 1'b1; op = ~o;
            @(negedge clk);
        end
        start = 1'b0;
    endtask

    task automatic wrap_up();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state at the ports
        check_val("R1 mem_rd", {15'd0, mem_rd}, 16'd0);
        check_val("R1 mem_wr", {15'd0, mem_wr}, 16'd0);
        check_val("R1 done", {15'd0, done}, 16'd0);
        check_val("R1 mem_addr", mem_addr, 16'h0000);
        check_val("R1 mem_wdata", {8'd0, mem_wdata}, 16'h0000);

        run_op(2'b01, 1'b0);  // R1/R5: first push lands at 0xFFFF
        run_op(2'b00, 1'b1);  // fetch 200 with stray start (R9)
        run_op(2'b10, 1'b0);  // A = 200
        run_op(2'b00, 1'b0);  // fetch 237
        run_op(2'b11, 1'b0);  // R = 181, wraps (R8)
        run_op(2'b01, 1'b1);  // push 181 with stray start (R9)
        run_op(2'b00, 1'b0);  // fetch 18
        run_op(2'b10, 1'b0);  // A = 18 (R7)
        run_op(2'b00, 1'b0);  // fetch 55
        run_op(2'b11, 1'b0);  // R = 73
        run_op(2'b01, 1'b0);
        run_op(2'b01, 1'b0);
        wait (exp_q.size() == 0);
        repeat (4) @(negedge clk);
        check_val("R10 queue drained", 16'(exp_q.size()), 16'd0);
        finished = 1'b1;
        wrap_up();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: run did not complete, expected finish");
            wrap_up();
        end
    end

endmodule